// File: doc/BRIEF.md
# External Interrupt Sense Normalizer

This block sits between two external interrupt pins and an upstream interrupt controller that accepts only active-high levels or rising edges. Each pin has its own configuration word. The word turns the line on, chooses level or edge sensing, and chooses which polarity counts as active. The block first passes each pin through a reset-cleared synchronizer. It then corrects the polarity. In level mode it forwards the result as a level. In edge mode it turns each qualifying transition into a one-cycle pulse. A pin that is active low, or that signals on a falling edge, therefore looks upstream like an active-high level or a rising edge.

Software reaches the configuration words through a simple word-addressed register port. Writes take effect at the clock edge. Reads are combinational and return data in the same cycle. When a configuration word is written, the line's edge history is reloaded so that the new setting starts from the pin's present state. A change of sense or polarity therefore never produces a pulse of its own.

Top module: `eint_normalizer`

## Requirements
- R1: After reset, every register reads as zero and both `irqOut` bits are low.
- R2: The configuration word of line x sits at byte address 4 + 4·x (line 0 at 0x4, line 1 at 0x8). In it, bit 16 is enable, bit 9 selects level sensing (1) or edge sensing (0), and bit 8 is polarity. A read returns those three bits as written, and every other bit reads as zero.
- R3: Byte address 0x0, the unmapped word 0xC, and any address whose two low bits are nonzero all read as zero. Writes to them leave both lines' configuration and outputs unchanged.
- R4: While a line's enable bit is 0, its output stays low whatever its pin does.
- R5: With level sensing and polarity 1, the output equals the pin as it was sampled two clock edges earlier.
- R6: With level sensing and polarity 0, the output is the inverse of the pin as it was sampled two clock edges earlier.
- R7: With edge sensing and polarity 0, each 0→1 transition of the synchronized pin gives exactly one cycle of output high. Nothing else drives the output high.
- R8: With edge sensing and polarity 1, each 1→0 transition of the synchronized pin gives exactly one cycle of output high.
- R9: A write to a line's configuration word never produces an output pulse by itself. A pulse comes only from a pin transition that follows the write.
- R10: Writing zero to a configuration word disables the line, clears its sense and polarity, and forces its output low.
- R11: The two lines are independent. Configuration and pin activity on one never change the other's register contents or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte address for both read and write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for `busAddr` |
| pinRaw | input | LINES | Asynchronous external interrupt pins |
| irqOut | output | LINES | Normalized active-high level or rising-edge pulse per line |

## Verification
The pins are driven with slow square waves, single-cycle glitches, and, in a final long stretch, random toggling on both lines at once under different modes. The square waves confirm the two-edge latency and the level inversion. The glitches confirm that edge mode gives one pulse per transition rather than a stretched level, and separate rising from falling detection. Configuration is rewritten while a pin is held at its active value. This shows whether a pulse comes from the write or only from a later pin transition. Writes to the global, unmapped and misaligned addresses, and writes of all ones, check that the address decode is exact and that undefined bits are dropped.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
package eint_pkg;
  // Bit positions inside a line configuration word
  localparam int CFG_EN_BIT  = 16;
  localparam int CFG_LVL_BIT = 9;
  localparam int CFG_POL_BIT = 8;

  // Stored per-line configuration
  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
  } lineCfg_t;

  // Strobes from control to datapath, one per line
  typedef struct packed {
    logic reload;     // configuration word written this cycle
    logic newInvert;  // inversion the line will use after the write
  } lineStrobe_t;

  // Level sensing treats polarity 1 as active high, while edge sensing
  // treats polarity 0 as rising; inversion is therefore lvl xor pol.
  function automatic logic invertOf(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction
endpackage

// File: rtl/eint_ctrl.sv
`timescale 1ns/1ps
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int LINES  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busWrEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWrData,
  output logic [DATA_W-1:0]        busRdData,
  output lineCfg_t [LINES-1:0]     lineCfg,
  output lineStrobe_t [LINES-1:0]  lineStrobe
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  lineCfg_t         wrCfg;
  logic             unusedWrBits;

  assign wordIdx      = busAddr[ADDR_W-1:2];
  assign aligned      = (busAddr[1:0] == 2'b00);
  assign unusedWrBits = ^busWrData;

  always_comb begin
    wrCfg.en  = busWrData[CFG_EN_BIT];
    wrCfg.lvl = busWrData[CFG_LVL_BIT];
    wrCfg.pol = busWrData[CFG_POL_BIT];
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic     hit;
    lineCfg_t cfgQ;

    // Word 0 is the global register; lines start at word 1
    assign hit = busWrEn && aligned && (wordIdx == IDX_W'(g + 1));

    always_ff @(posedge clk or posedge rst) begin
      if (rst)      cfgQ <= '0;
      else if (hit) cfgQ <= wrCfg;
    end

    assign lineCfg[g]              = cfgQ;
    assign lineStrobe[g].reload    = hit;
    assign lineStrobe[g].newInvert = invertOf(wrCfg.lvl, wrCfg.pol);
  end

  always_comb begin
    busRdData = '0;
    for (int l = 0; l < LINES; l++) begin
      if (aligned && (wordIdx == IDX_W'(l + 1))) begin
        busRdData[CFG_EN_BIT]  = lineCfg[l].en;
        busRdData[CFG_LVL_BIT] = lineCfg[l].lvl;
        busRdData[CFG_POL_BIT] = lineCfg[l].pol;
      end
    end
  end
endmodule

// File: rtl/eint_sync.sv
`timescale 1ns/1ps
module eint_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/eint_datapath.sv
`timescale 1ns/1ps
module eint_datapath
  import eint_pkg::*;
#(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LINES-1:0]        pinRaw,
  input  lineCfg_t [LINES-1:0]    lineCfg,
  input  lineStrobe_t [LINES-1:0] lineStrobe,
  output logic [LINES-1:0]        irqOut
);
  logic [LINES-1:0] pinSync;

  eint_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pinRaw),
    .dout (pinSync)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    logic norm;
    logic histQ;

    assign norm = pinSync[g] ^ invertOf(lineCfg[g].lvl, lineCfg[g].pol);

    // History follows the corrected pin; on a config write it is loaded
    // with the pin corrected by the new setting so no false edge appears.
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                       histQ <= 1'b0;
      else if (lineStrobe[g].reload) histQ <= pinSync[g] ^ lineStrobe[g].newInvert;
      else                           histQ <= norm;
    end

    always_comb begin
      if (!lineCfg[g].en)      irqOut[g] = 1'b0;
      else if (lineCfg[g].lvl) irqOut[g] = norm;
      else                     irqOut[g] = norm & ~histQ;
    end
  end
endmodule

// File: rtl/eint_normalizer.sv
`timescale 1ns/1ps
module eint_normalizer
  import eint_pkg::*;
#(
  parameter int LINES  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [LINES-1:0]  pinRaw,
  output logic [LINES-1:0]  irqOut
);
  lineCfg_t    [LINES-1:0] lineCfg;
  lineStrobe_t [LINES-1:0] lineStrobe;

  eint_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .lineCfg    (lineCfg),
    .lineStrobe (lineStrobe)
  );

  eint_datapath #(.LINES(LINES), .SYNC_STAGES(2)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .pinRaw     (pinRaw),
    .lineCfg    (lineCfg),
    .lineStrobe (lineStrobe),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/eint_normalizer_chk.sv
`timescale 1ns/1ps
module eint_normalizer_chk
  import eint_pkg::*;
#(
  parameter int LINES  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busWrEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busRdData,
  input logic [LINES-1:0]     pinRaw,
  input logic [LINES-1:0]     irqOut,
  input lineCfg_t [LINES-1:0] lineCfg
);
  localparam logic [DATA_W-1:0] RD_MASK = (DATA_W'(1) << CFG_EN_BIT)
                                        | (DATA_W'(1) << CFG_LVL_BIT)
                                        | (DATA_W'(1) << CFG_POL_BIT);

  logic [1:0] aliveCnt;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                   aliveCnt <= '0;
    else if (aliveCnt != 2'd3) aliveCnt <= aliveCnt + 2'd1;
  end

  // R2
  rd_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (busRdData & ~RD_MASK) == '0);

  // R3
  global_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr[ADDR_W-1:2] == '0) |=> $stable(lineCfg));

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !lineCfg[g].en |-> !irqOut[g]);

    // R5
    level_high_chk: assert property (@(posedge clk) disable iff (rst)
      (aliveCnt == 2'd3 && lineCfg[g].en && lineCfg[g].lvl && lineCfg[g].pol)
        |-> irqOut[g] == $past(pinRaw[g], 2));

    // R6
    level_low_chk: assert property (@(posedge clk) disable iff (rst)
      (aliveCnt == 2'd3 && lineCfg[g].en && lineCfg[g].lvl && !lineCfg[g].pol)
        |-> irqOut[g] == !$past(pinRaw[g], 2));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      (lineCfg[g].en && !lineCfg[g].lvl && irqOut[g])
        |=> (!$stable(lineCfg[g]) || !irqOut[g]));
  end
endmodule

bind eint_normalizer eint_normalizer_chk #(
  .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .pinRaw    (pinRaw),
  .irqOut    (irqOut),
  .lineCfg   (lineCfg)
);

// File: tb/eint_normalizer_tb.sv
`timescale 1ns/1ps
module eint_normalizer_tb_top;
  localparam int LINES  = 2;
  localparam int ADDR_W = 4;
  localparam logic [31:0] MASK = 32'h0001_0300;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [LINES-1:0]  pinRaw = '0;
  logic [LINES-1:0]  irqOut;

  int    checks = 0;
  int    fails = 0;
  bit    running = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;  // 50 MHz

  eint_normalizer #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .pinRaw(pinRaw), .irqOut(irqOut)
  );

  // ---------------- behavioural reference ----------------
  bit          pinHist [LINES][$];  // newest first; [1] is the synced pin
  logic [31:0] mCfg [LINES];
  bit          mPrev [LINES];

  function automatic bit mInv(input logic [31:0] c);
    return c[9] ^ c[8];
  endfunction

  function automatic bit mExpect(input int l);
    bit corr;
    corr = pinHist[l][1] ^ mInv(mCfg[l]);
    if (!mCfg[l][16]) return 1'b0;
    if (mCfg[l][9])   return corr;
    return corr & !mPrev[l];
  endfunction

  function automatic string modeTag(input int l);
    if (!mCfg[l][16]) return "R4";
    if (mCfg[l][9])   return mCfg[l][8] ? "R5" : "R6";
    return mCfg[l][8] ? "R8" : "R7";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LINES; l++) begin
        pinHist[l] = '{1'b0, 1'b0};
        mCfg[l] = '0;
        mPrev[l] = 1'b0;
      end
    end else begin
      for (int l = 0; l < LINES; l++) begin : upd
        logic [31:0] nc;
        nc = (busWrEn && int'(busAddr) == 4 * (l + 1)) ? (busWrData & MASK) : mCfg[l];
        mPrev[l] = pinHist[l][1] ^ mInv(nc);
        pinHist[l].push_front(pinRaw[l]);
        void'(pinHist[l].pop_back());
        mCfg[l] = nc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison of both outputs against the model
  always @(negedge clk) begin
    if (running) begin
      for (int l = 0; l < LINES; l++)
        check(irqOut[l] === mExpect(l),
              $sformatf("%s/%s line%0d", modeTag(l), phase, l),
              32'(irqOut[l]), 32'(mExpect(l)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    check(busRdData === exp, req, busRdData, exp);
  endtask

  task automatic setPin(input int l, input bit v, input int cycles);
    @(negedge clk);
    pinRaw[l] = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic squareWave(input int l, input int periods, input int half);
    for (int p = 0; p < periods; p++) begin
      setPin(l, 1'b1, half);
      setPin(l, 1'b0, half);
    end
  endtask

  task automatic glitches(input int l, input bit base, input int count);
    for (int p = 0; p < count; p++) begin
      setPin(l, ~base, 0);
      setPin(l, base, 3);
    end
  endtask

  // Checks the output stays low for n cycles (explicit, beyond the model)
  task automatic expectQuiet(input int l, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      check(irqOut[l] === 1'b0, req, 32'(irqOut[l]), 32'd0);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    running = 1'b1;

    // R1: reset state
    phase = "R1";
    regRead(4'h0, 32'h0, "R1 global");
    regRead(4'h4, 32'h0, "R1 line0 cfg");
    regRead(4'h8, 32'h0, "R1 line1 cfg");
    check(irqOut === 2'b00, "R1 irqOut", 32'(irqOut), 32'd0);

    // R4: disabled lines ignore pins
    phase = "R4";
    squareWave(0, 3, 2);
    squareWave(1, 3, 3);
    expectQuiet(0, 2, "R4 line0 disabled");

    // R2: register contents and masking
    phase = "R2";
    regWrite(4'h8, 32'hFFFF_FFFF);
    regRead(4'h8, 32'h0001_0300, "R2 line1 masked all-ones");
    regRead(4'h4, 32'h0, "R11 line0 untouched by line1 write");
    regWrite(4'h8, 32'h0);

    // R5: level, active high
    phase = "R5";
    regWrite(4'h4, 32'h0001_0300);
    regRead(4'h4, 32'h0001_0300, "R2 line0 readback");
    squareWave(0, 4, 3);
    glitches(0, 1'b0, 2);

    // R6: level, active low
    phase = "R6";
    regWrite(4'h4, 32'h0001_0200);
    regRead(4'h4, 32'h0001_0200, "R2 line0 level-low readback");
    squareWave(0, 4, 2);

    // R7: rising edge
    phase = "R7";
    regWrite(4'h4, 32'h0001_0000);
    squareWave(0, 4, 4);
    glitches(0, 1'b0, 3);

    // R8: falling edge
    phase = "R8";
    regWrite(4'h4, 32'h0001_0100);
    squareWave(0, 4, 4);
    glitches(0, 1'b1, 3);

    // R9: config changes with the pin held active make no pulse
    phase = "R9";
    setPin(0, 1'b1, 4);
    regWrite(4'h4, 32'h0001_0100);
    expectQuiet(0, 3, "R9 falling mode, pin high");
    regWrite(4'h4, 32'h0001_0000);
    expectQuiet(0, 3, "R9 switch to rising, pin high");
    regWrite(4'h4, 32'h0001_0300);
    repeat (2) @(negedge clk);
    regWrite(4'h4, 32'h0001_0000);
    expectQuiet(0, 3, "R9 level to rising, pin high");
    regWrite(4'h4, 32'h0000_0000);
    regWrite(4'h4, 32'h0001_0000);
    expectQuiet(0, 3, "R9 re-enable, pin high");
    setPin(0, 1'b0, 4);

    // R3: global, unmapped and misaligned accesses are inert
    phase = "R3";
    regWrite(4'h8, 32'h0001_0200);
    regWrite(4'h0, 32'hFFFF_FFFF);
    regWrite(4'hC, 32'hFFFF_FFFF);
    regWrite(4'h5, 32'h0000_0000);
    regWrite(4'h9, 32'h0000_0000);
    regRead(4'h0, 32'h0, "R3 global reads zero");
    regRead(4'hC, 32'h0, "R3 unmapped reads zero");
    regRead(4'h5, 32'h0, "R3 misaligned reads zero");
    regRead(4'h4, 32'h0001_0000, "R3 line0 unchanged");
    regRead(4'h8, 32'h0001_0200, "R3 line1 unchanged");

    // R11: both lines active in different modes, random pins
    phase = "R11";
    regWrite(4'h4, 32'h0001_0100);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      pinRaw = 2'($urandom_range(0, 3));
    end
    regWrite(4'h4, 32'h0001_0000);
    regWrite(4'h8, 32'h0001_0300);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      pinRaw = 2'($urandom_range(0, 3));
    end

    // R10: writing zero disables and clears
    phase = "R10";
    regWrite(4'h4, 32'h0);
    regWrite(4'h8, 32'h0);
    regRead(4'h4, 32'h0, "R10 line0 cleared");
    regRead(4'h8, 32'h0, "R10 line1 cleared");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pinRaw = 2'($urandom_range(0, 3));
      #1;
      check(irqOut === 2'b00, "R10 outputs low", 32'(irqOut), 32'd0);
    end

    repeat (4) @(negedge clk);
    running = 1'b0;
    summary();
    $finish;
  end
endmodule